// File: doc/BRIEF.md
# Two-Pass Subranging Conversion Sequencer

This block holds the timing and control for a sampling converter that resolves each sample in two flash passes. A rising edge on the trigger input puts the sample-and-hold into hold mode and starts a cycle-counted routine. First the block strobes the coarse flash reading and captures it. It presents that code to the reference DAC and then waits a fixed interval for the DAC and the residue amplifier to settle. Next it strobes the fine flash reading and releases the sample-and-hold back to sample mode. Last it publishes the corrected output word together with a transfer pulse.

The fine pass overlaps the coarse pass by two bits. The block adds the coarse code, weighted by the output-bit shift, to the fine code and removes a fixed mid-range offset. The result is clamped to the output range, and a range flag is raised when clamping occurs. While a conversion runs, later trigger edges are ignored and the previous word stays on the outputs. A parameter picks the speed grade, which sets the settling interval. A second parameter picks plain binary or two's-complement output coding.

Top module: `subrange_conv_seq`

## Requirements
- R1: A synchronous reset (rst high) leaves sh_hold_o, coarse_stb_o, dac_load_o, fine_stb_o, xfer_o and range_err_o low. It also clears the stored word, which reads 0x0000 with binary coding and 0x8000 with two's-complement coding.
- R2: A low-to-high trigger change is sampled on a clock edge. If the block is idle at that edge, sh_hold_o is high (hold) from that edge on.
- R3: coarse_stb_o is high for exactly one cycle, the P1_CYC-th cycle after the starting edge. In the following cycle dac_load_o pulses for one cycle and dac_code_o shows the flash_i value sampled at the end of the strobe cycle.
- R4: fine_stb_o is high for exactly one cycle, SETTLE+1 cycles after the coarse strobe. SETTLE is SETTLE_FAST_CYC when FAST_GRADE=1 and SETTLE_SLOW_CYC otherwise. flash_i is sampled at the end of that cycle.
- R5: sh_hold_o returns low in the cycle right after the fine strobe, so hold lasts P1_CYC+SETTLE+1 cycles.
- R6: data_o changes only in the cycle xfer_o rises. Until then it keeps the previous conversion's word.
- R7: The word equals coarse*2^(OUT_W-FLASH_W) + fine - (2^FLASH_W - 2^(OUT_W-FLASH_W))/2, which is coarse*128 + fine - 192 by default. Results below 0 give 0 and results above 2^OUT_W-1 give 2^OUT_W-1. In both cases range_err_o is 1; otherwise range_err_o is 0.
- R8: xfer_o stays high for exactly XFER_CYC cycles, and then the block is idle again.
- R9: Trigger edges that arrive while sh_hold_o or xfer_o is high are ignored. They neither restart nor lengthen the routine, and they start no later conversion.
- R10: A trigger that is already high when reset releases, or that stays high after a conversion ends, starts nothing until it goes low and rises again.
- R11: With TWOS_COMP=1, data_o is the R7 word with its most significant bit inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | 1 | Conversion trigger, rising edge starts |
| flash_i | input | FLASH_W | Flash converter code, used for both passes |
| sh_hold_o | output | 1 | 1 = hold, 0 = sample |
| coarse_stb_o | output | 1 | First-pass flash capture strobe |
| dac_load_o | output | 1 | Reference DAC load pulse |
| dac_code_o | output | FLASH_W | Code applied to the reference DAC |
| fine_stb_o | output | 1 | Second-pass flash capture strobe |
| xfer_o | output | 1 | Transfer pulse; data valid at its rising edge |
| data_o | output | OUT_W | Corrected output word |
| range_err_o | output | 1 | Word was clamped at a range end |

## Verification
A wrong sequencer state shows first as a strobe or a hold edge in the wrong cycle, within one cycle of the fault. A wrong count in the timer shifts the fine strobe and the transfer rise by the same amount, so measuring the hold length exposes it at the end of that conversion. A fault in the correction arithmetic stays hidden until a transfer, and then shows as a wrong word or range flag. Faults in the capture registers or the coding option likewise appear at the next transfer. Any loss of the trigger lockout shows up as extra hold periods after the routine ends.

// File: rtl/subrange_pkg.sv
`timescale 1ns/1ps
package subrange_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_HOLD_P1  = 3'd1,
      ST_SETTLE   = 3'd2,
      ST_P2_LATCH = 3'd3,
      ST_OUTPUT   = 3'd4
   } seq_state_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/subrange_cycle_timer.sv
`timescale 1ns/1ps
module subrange_cycle_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/subrange_seq_fsm.sv
`timescale 1ns/1ps
module subrange_seq_fsm
   import subrange_pkg::*;
#(
   parameter int P1_CYC     = 10,
   parameter int SETTLE_CYC = 110,
   parameter int XFER_CYC   = 6,
   parameter int CNT_W      = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             trig_i,
   input  logic             tmr_zero,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             hold_o,
   output logic             coarse_stb_o,
   output logic             fine_stb_o,
   output logic             xfer_o
);

   seq_state_t state_q, state_d;
   logic       trig_q;
   logic       trig_edge;

   // Trigger history starts high so a level present at reset is not an edge (R10)
   always_ff @(posedge clk) begin
      if (rst)
         trig_q <= 1'b1;
      else
         trig_q <= trig_i;
   end

   assign trig_edge = trig_i & ~trig_q;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (trig_edge) begin
               state_d  = ST_HOLD_P1;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(P1_CYC - 1);
            end
         end
         ST_HOLD_P1: begin
            if (tmr_zero) begin
               state_d  = ST_SETTLE;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(SETTLE_CYC - 1);
            end
         end
         ST_SETTLE: begin
            if (tmr_zero)
               state_d = ST_P2_LATCH;
         end
         ST_P2_LATCH: begin
            state_d  = ST_OUTPUT;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(XFER_CYC - 1);
         end
         ST_OUTPUT: begin
            if (tmr_zero)
               state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= ST_IDLE;
      else
         state_q <= state_d;
   end

   assign hold_o       = (state_q == ST_HOLD_P1) || (state_q == ST_SETTLE) ||
                         (state_q == ST_P2_LATCH);
   assign coarse_stb_o = (state_q == ST_HOLD_P1) && tmr_zero;
   assign fine_stb_o   = (state_q == ST_P2_LATCH);
   assign xfer_o       = (state_q == ST_OUTPUT);

   // R2: an edge seen while idle starts the first pass
   a_r2_start: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && trig_edge) |=> (state_q == ST_HOLD_P1));

   // R9: a trigger during settling does not disturb the routine
   a_r9_lockout: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_SETTLE && trig_edge) |=>
         (state_q == ST_SETTLE || state_q == ST_P2_LATCH));

endmodule

// File: rtl/subrange_word_assembler.sv
`timescale 1ns/1ps
module subrange_word_assembler #(
   parameter int FLASH_W   = 9,
   parameter int OUT_W     = 16,
   parameter bit TWOS_COMP = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               coarse_stb,
   input  logic               fine_stb,
   input  logic [FLASH_W-1:0] flash_i,
   output logic [FLASH_W-1:0] dac_code_o,
   output logic               dac_load_o,
   output logic [OUT_W-1:0]   data_o,
   output logic               range_err_o
);

   localparam int          SHIFT    = OUT_W - FLASH_W;
   localparam int          OVERLAP  = FLASH_W - SHIFT;
   localparam int          FINE_OFS = ((1 << FLASH_W) - (1 << SHIFT)) / 2;
   localparam int          SUM_W    = OUT_W + 2;
   localparam logic [OUT_W-1:0] TOP_CODE = '1;

   generate
      if (SHIFT < 1)
         $error("subrange_word_assembler: OUT_W must exceed FLASH_W");
      if (OVERLAP < 1)
         $error("subrange_word_assembler: passes need at least one bit of overlap");
   endgenerate

   logic [FLASH_W-1:0] coarse_q;
   logic               dac_load_q;
   logic [OUT_W-1:0]   word_q;
   logic               err_q;
   logic [SUM_W-1:0]   c_ext, f_ext, raw;
   logic [OUT_W-1:0]   word_d;
   logic               err_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         coarse_q   <= '0;
         dac_load_q <= 1'b0;
      end else begin
         dac_load_q <= coarse_stb;
         if (coarse_stb)
            coarse_q <= flash_i;
      end
   end

   // Overlap correction: weighted coarse plus fine minus the mid-range offset
   always_comb begin
      c_ext = SUM_W'(coarse_q) << SHIFT;
      f_ext = SUM_W'(flash_i);
      raw   = c_ext + f_ext - SUM_W'(FINE_OFS);
      if (raw[SUM_W-1]) begin
         word_d = '0;
         err_d  = 1'b1;
      end else if (raw[SUM_W-2:OUT_W] != '0) begin
         word_d = TOP_CODE;
         err_d  = 1'b1;
      end else begin
         word_d = raw[OUT_W-1:0];
         err_d  = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         word_q <= '0;
         err_q  <= 1'b0;
      end else if (fine_stb) begin
         word_q <= word_d;
         err_q  <= err_d;
      end
   end

   generate
      if (TWOS_COMP) begin : g_twos
         assign data_o = {~word_q[OUT_W-1], word_q[OUT_W-2:0]};
      end else begin : g_binary
         assign data_o = word_q;
      end
   endgenerate

   assign dac_code_o  = coarse_q;
   assign dac_load_o  = dac_load_q;
   assign range_err_o = err_q;

   // R7: a raised range flag means the word sits at one end of the scale
   a_r7_err_clamped: assert property (@(posedge clk) disable iff (rst)
      range_err_o |-> (word_q == '0 || word_q == TOP_CODE));

   // R3: the DAC is loaded with the code present at the coarse strobe
   a_r3_dac_code: assert property (@(posedge clk) disable iff (rst)
      dac_load_o |-> (dac_code_o == $past(flash_i)));

endmodule

// File: rtl/subrange_conv_seq.sv
`timescale 1ns/1ps
module subrange_conv_seq
   import subrange_pkg::*;
#(
   parameter int FLASH_W         = 9,
   parameter int OUT_W           = 16,
   parameter bit FAST_GRADE      = 1'b1,
   parameter int P1_CYC          = 10,
   parameter int SETTLE_FAST_CYC = 110,
   parameter int SETTLE_SLOW_CYC = 230,
   parameter int XFER_CYC        = 6,
   parameter bit TWOS_COMP       = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               trig_i,
   input  logic [FLASH_W-1:0] flash_i,
   output logic               sh_hold_o,
   output logic               coarse_stb_o,
   output logic               dac_load_o,
   output logic [FLASH_W-1:0] dac_code_o,
   output logic               fine_stb_o,
   output logic               xfer_o,
   output logic [OUT_W-1:0]   data_o,
   output logic               range_err_o
);

   localparam int SETTLE_CYC = FAST_GRADE ? SETTLE_FAST_CYC : SETTLE_SLOW_CYC;
   localparam int MAX_CYC    = max3(P1_CYC, SETTLE_CYC, XFER_CYC);
   localparam int CNT_W      = $clog2(MAX_CYC + 1);

   generate
      if (P1_CYC < 1 || SETTLE_CYC < 1 || XFER_CYC < 1)
         $error("subrange_conv_seq: every interval needs at least one cycle");
   endgenerate

   logic             tmr_load, tmr_zero;
   logic [CNT_W-1:0] tmr_val, tmr_cnt;

   subrange_cycle_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .cnt_o    (tmr_cnt),
      .zero_o   (tmr_zero)
   );

   subrange_seq_fsm #(
      .P1_CYC     (P1_CYC),
      .SETTLE_CYC (SETTLE_CYC),
      .XFER_CYC   (XFER_CYC),
      .CNT_W      (CNT_W)
   ) u_fsm (
      .clk          (clk),
      .rst          (rst),
      .trig_i       (trig_i),
      .tmr_zero     (tmr_zero),
      .tmr_load     (tmr_load),
      .tmr_val      (tmr_val),
      .hold_o       (sh_hold_o),
      .coarse_stb_o (coarse_stb_o),
      .fine_stb_o   (fine_stb_o),
      .xfer_o       (xfer_o)
   );

   subrange_word_assembler #(
      .FLASH_W   (FLASH_W),
      .OUT_W     (OUT_W),
      .TWOS_COMP (TWOS_COMP)
   ) u_asm (
      .clk         (clk),
      .rst         (rst),
      .coarse_stb  (coarse_stb_o),
      .fine_stb    (fine_stb_o),
      .flash_i     (flash_i),
      .dac_code_o  (dac_code_o),
      .dac_load_o  (dac_load_o),
      .data_o      (data_o),
      .range_err_o (range_err_o)
   );

   // R6: the published word moves only together with the transfer rise
   a_r6_data_holds: assert property (@(posedge clk) disable iff (rst)
      !$rose(xfer_o) |-> $stable(data_o));

   // R5: the fine capture hands the sample-and-hold back and starts the transfer
   a_r5_sample_after_fine: assert property (@(posedge clk) disable iff (rst)
      fine_stb_o |=> (!sh_hold_o && xfer_o));

   // R3: the coarse strobe is a single-cycle pulse inside a hold period
   a_r3_single_coarse: assert property (@(posedge clk) disable iff (rst)
      coarse_stb_o |-> (sh_hold_o ##1 !coarse_stb_o));

   // R8: the transfer pulse never overlaps hold
   a_r8_xfer_not_hold: assert property (@(posedge clk) disable iff (rst)
      !(xfer_o && sh_hold_o));

endmodule

// File: tb/subrange_conv_seq_tb.sv
`timescale 1ns/1ps
module subrange_conv_seq_tb;

   localparam int FW = 9;
   localparam int OW = 16;
   localparam int P1 = 10;
   localparam int ST = 110;
   localparam int XC = 6;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          trig = 1'b0;
   logic [FW-1:0] flash;
   logic [FW-1:0] coarse_v = '0, fine_v = '0;

   logic          hold, cstb, dload, fstb, xfer, rerr;
   logic [FW-1:0] dcode;
   logic [OW-1:0] data;
   logic          hold_tc, cstb_tc, dload_tc, fstb_tc, xfer_tc, rerr_tc;
   logic [FW-1:0] dcode_tc;
   logic [OW-1:0] data_tc;

   int n_chk = 0, n_fail = 0;
   int prev_word = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   // Flash model: the converter shows the coarse reading, then the fine one
   assign flash = fstb ? fine_v : coarse_v;

   subrange_conv_seq #(.P1_CYC(P1), .SETTLE_FAST_CYC(ST), .XFER_CYC(XC)) u_dut (
      .clk(clk), .rst(rst), .trig_i(trig), .flash_i(flash),
      .sh_hold_o(hold), .coarse_stb_o(cstb), .dac_load_o(dload),
      .dac_code_o(dcode), .fine_stb_o(fstb), .xfer_o(xfer),
      .data_o(data), .range_err_o(rerr));

   subrange_conv_seq #(.P1_CYC(P1), .SETTLE_FAST_CYC(ST), .XFER_CYC(XC),
                       .TWOS_COMP(1'b1)) u_dut_tc (
      .clk(clk), .rst(rst), .trig_i(trig), .flash_i(flash),
      .sh_hold_o(hold_tc), .coarse_stb_o(cstb_tc), .dac_load_o(dload_tc),
      .dac_code_o(dcode_tc), .fine_stb_o(fstb_tc), .xfer_o(xfer_tc),
      .data_o(data_tc), .range_err_o(rerr_tc));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int ref_word(input int c, input int f, output bit err);
      int v;
      v = c * 128 + f - 192;
      err = 1'b0;
      if (v < 0) begin v = 0; err = 1'b1; end
      if (v > 65535) begin v = 65535; err = 1'b1; end
      return v;
   endfunction

   task automatic idle_quiet(input int n, input string req);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (hold || xfer) seen++;
      end
      chk(seen == 0, req, "busy cycles while no valid edge", seen, 0);
   endtask

   task automatic conv(input int c, input int f, input bit retrig,
                       input bit keep_high, input string tag);
      int  hold_n = 0, c_idx = -1, d_idx = -1, d_val = -1, f_idx = -1;
      int  x_idx = -1, pre = -1, w = 0, exp_w, hold1 = 0;
      bit  exp_e;
      coarse_v = FW'(c);
      fine_v   = FW'(f);
      exp_w    = ref_word(c, f, exp_e);
      @(negedge clk);
      trig = 1'b1;
      for (int i = 1; i <= 600; i++) begin
         @(negedge clk);
         if (i == 25 && !keep_high) trig = 1'b0;
         if (retrig) begin
            if (i == 40 || i == 80) trig = 1'b1;
            if (i == 60 || i == 100) trig = 1'b0;
         end
         if (i == 1) hold1 = hold;
         if (hold) hold_n++;
         if (cstb) c_idx = i;
         if (dload) begin d_idx = i; d_val = dcode; end
         if (fstb) begin f_idx = i; pre = data; end
         if (xfer) begin x_idx = i; break; end
      end
      chk(hold1 == 1, "R2", {tag, " hold right after edge"}, hold1, 1);
      chk(c_idx == P1, "R3", {tag, " coarse strobe cycle"}, c_idx, P1);
      chk(d_idx == P1 + 1 && d_val == c, "R3", {tag, " dac code"}, d_val, c);
      chk(f_idx == P1 + ST + 1, "R4", {tag, " fine strobe cycle"}, f_idx, P1 + ST + 1);
      chk(hold_n == P1 + ST + 1, "R5", {tag, " hold length"}, hold_n, P1 + ST + 1);
      chk(pre == prev_word, "R6", {tag, " old word kept"}, pre, prev_word);
      chk(data == exp_w, "R7", {tag, " word"}, data, exp_w);
      chk(rerr == exp_e, "R7", {tag, " range flag"}, rerr, exp_e);
      chk(data_tc == (exp_w ^ 32'h8000), "R11", {tag, " two's complement word"},
          data_tc, exp_w ^ 32'h8000);
      w = 1;
      for (int i = 0; i < 50 && xfer; i++) begin
         @(negedge clk);
         if (xfer) w++;
      end
      chk(w == XC, "R8", {tag, " transfer width"}, w, XC);
      chk(data == exp_w, "R6", {tag, " word stable after transfer"}, data, exp_w);
      prev_word = exp_w;
      if (retrig) idle_quiet(40, "R9");
      if (keep_high) begin
         idle_quiet(40, "R10");
         trig = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(!hold && !cstb && !dload && !fstb && !xfer && !rerr, "R1",
          "control outputs low", {hold, cstb, dload, fstb, xfer, rerr}, 0);
      chk(data == 0, "R1", "binary word after reset", data, 0);
      chk(data_tc == 16'h8000, "R1", "two's complement word after reset", data_tc, 16'h8000);
   endtask

   task automatic t_reset_trig_high;
      @(negedge clk);
      trig = 1'b1;
      rst  = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      idle_quiet(30, "R10");
      trig = 1'b0;
      prev_word = 0;
      @(negedge clk);
   endtask

   task automatic t_overlap;
      int a, b;
      bit e;
      a = ref_word(100, 323, e);
      b = ref_word(101, 195, e);
      chk(a == b, "R7", "overlap gives equal words", a, b);
      conv(100, 323, 1'b0, 1'b0, "overlap hi");
      conv(101, 195, 1'b0, 1'b0, "overlap lo");
   endtask

   initial begin
      #(5ns * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      conv(256, 192, 1'b0, 1'b0, "mid scale");
      conv(0, 197, 1'b0, 1'b0, "near zero");
      conv(0, 0, 1'b0, 1'b0, "underflow");
      conv(511, 511, 1'b0, 1'b0, "overflow");
      t_overlap();
      conv(300, 250, 1'b1, 1'b0, "retrigger");
      conv(50, 60, 1'b0, 1'b1, "held trigger");
      conv(77, 300, 1'b0, 1'b0, "back to back");
      t_reset_trig_high();
      conv(400, 100, 1'b0, 1'b0, "after reset");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule